// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller. It groups its pins into banks of 32. Every bank holds its own registers for pin level, direction, output, rising-edge enable, falling-edge enable, edge status and interrupt mask. Software drives outputs only through write-one set and write-one clear registers, so it never has to do a read-modify-write on the output state.

Pad inputs pass through a two-flop synchronizer. A transition on a synchronized input that its enable allows latches a sticky status bit. Software clears a status bit by writing a one to it. A single interrupt line stays high while any status bit is pending and its mask bit is set.

The register bus is single-cycle. A request with `we_i` high writes on the clock edge. A request with `we_i` low returns data on `rdata_o` one clock later. The register groups are interleaved: each group is a block of one word per bank. Banks 0 to 2 fill the low block, and banks 3 to 5 fill an identical block based at byte 0x100.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the direction, output, rising-enable, falling-enable and status registers are zero. Every implemented mask bit is one. `irq_o`, `pad_out_o` and `pad_oe_o` are low.
- R2: Each group has a fixed byte base: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48, mask 0x9C. Bank n sits at base + 4·n for n < 3, and at base + 0x100 + 4·(n−3) for n ≥ 3. Bit k of a bank register belongs to pin 32·n + k.
- R3: The level register returns the synchronized pad input of every pin, whatever its direction, two clock edges after the pad changes. Reads of the set and clear registers return zero.
- R4: A direction bit of 1 drives the pin's `pad_oe_o` high. Writing a 1 to a set-register bit drives that pin's `pad_out_o` high on the next edge. Writing a 1 to a clear-register bit drives it low. Zero bits leave the output unchanged.
- R5: A rising synchronized transition sets the pin's status bit only when its rising enable is 1. A falling transition does the same only when its falling enable is 1. A pin with both enables set captures both edges. Status bits are sticky and become visible three clock edges after the pad change.
- R6: Writing ones to the status register clears those bits. Zero bits have no effect, and writing all ones clears every pending bit.
- R7: If a new enabled edge and a write-one clear hit the same status bit on the same clock edge, the bit stays set.
- R8: `irq_o` is high exactly while some bank has a status bit set whose mask bit is 1. Clearing a mask bit hides that status from `irq_o` but leaves the status readable.
- R9: In the last bank, bits above the implemented pin count read as zero and ignore writes.
- R10: Offsets that map to no register, including banks that are not built, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| pad_in_i | input | NUM_PINS | Asynchronous pad inputs |
| pad_out_o | output | NUM_PINS | Pad output levels |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
The checks follow the latencies that come from the block's own registers:
- A register write takes effect on the clock edge that accepts it, so `pad_out_o`, `pad_oe_o` and `irq_o` are sampled on the falling edge that follows.
- Read data appears on the edge after the request. A scoreboard entry pushed with the request is compared one falling edge later.
- A pad change reaches the level register after two edges and the status bit after three. The interrupt is checked both low after the second edge and high after the third.
- The edge-versus-clear collision is set up by issuing the clear write so that the clock edge accepting it is exactly the third edge after the pad change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BANK_W     = 32;
  localparam int unsigned ADDR_W     = 9;
  localparam int unsigned MAX_BANKS  = 6;

  // group index = word offset / 3 inside each 0x100 block
  typedef enum logic [3:0] {
    G_LEVEL = 4'd0,
    G_DIR   = 4'd1,
    G_SET   = 4'd2,
    G_CLR   = 4'd3,
    G_RISE  = 4'd4,
    G_FALL  = 4'd5,
    G_STAT  = 4'd6,
    G_MASK  = 4'd13,
    G_NONE  = 4'd15
  } grp_e;

  typedef struct packed {
    logic       hit;
    grp_e       grp;
    logic [2:0] bank;
  } dec_t;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int unsigned nb);
    dec_t       d;
    logic [5:0] w, q, r;
    w      = a[7:2];
    q      = w / 6'd3;
    r      = w % 6'd3;
    d.bank = 3'(r) + (a[8] ? 3'd3 : 3'd0);
    case (q)
      6'd0:    d.grp = G_LEVEL;
      6'd1:    d.grp = G_DIR;
      6'd2:    d.grp = G_SET;
      6'd3:    d.grp = G_CLR;
      6'd4:    d.grp = G_RISE;
      6'd5:    d.grp = G_FALL;
      6'd6:    d.grp = G_STAT;
      6'd13:   d.grp = G_MASK;
      default: d.grp = G_NONE;
    endcase
    d.hit = (a[1:0] == 2'b00) && (d.grp != G_NONE) && (32'(d.bank) < nb);
    return d;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pin_i,
  input  logic            wr_i,
  input  grp_e            grp_i,
  input  logic [PINS-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic [PINS-1:0] dir_o,
  output logic [PINS-1:0] out_o,
  output logic            irq_o
);
  logic [PINS-1:0] dir_q, out_q, rise_q, fall_q, stat_q, mask_q, prev_q;
  logic [PINS-1:0] edge_hit, stat_clr;

  assign edge_hit = (pin_i & ~prev_q & rise_q) | (~pin_i & prev_q & fall_q);
  assign stat_clr = (wr_i && grp_i == G_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '1;
    end else if (wr_i) begin
      case (grp_i)
        G_DIR:   dir_q  <= wdata_i;
        G_SET:   out_q  <= out_q | wdata_i;
        G_CLR:   out_q  <= out_q & ~wdata_i;
        G_RISE:  rise_q <= wdata_i;
        G_FALL:  fall_q <= wdata_i;
        G_MASK:  mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // new edges take priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | edge_hit;
      prev_q <= pin_i;
    end
  end

  always_comb begin
    case (grp_i)
      G_LEVEL: rdata_o = BANK_W'(pin_i);
      G_DIR:   rdata_o = BANK_W'(dir_q);
      G_RISE:  rdata_o = BANK_W'(rise_q);
      G_FALL:  rdata_o = BANK_W'(fall_q);
      G_STAT:  rdata_o = BANK_W'(stat_q);
      G_MASK:  rdata_o = BANK_W'(mask_q);
      default: rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign irq_o = |(stat_q & mask_q);

  a_r4_set_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && grp_i == G_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));

  a_r4_clr_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && grp_i == G_CLR) |=> ((out_q & $past(wdata_i)) == '0));

  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && grp_i == G_STAT) |=> ((stat_q & $past(wdata_i & ~edge_hit)) == '0));

  a_r7_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && grp_i == G_STAT && (edge_hit & wdata_i) != '0)
      |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && grp_i == G_STAT) |=> ((~stat_q & $past(stat_q)) == '0));

  a_r5_only_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(edge_hit)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 120
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [8:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  // the address map holds at most MAX_BANKS banks
  localparam int unsigned NB    = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int unsigned PAD_W = NB * BANK_W;

  logic [NUM_PINS-1:0] sync_w;
  logic [PAD_W-1:0]    pins_all;
  logic [BANK_W-1:0]   bank_rd [NB];
  logic [NB-1:0]       bank_irq;
  logic [BANK_W-1:0]   rd_sel, rdata_q;
  dec_t                dec;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_w)
  );

  assign pins_all = PAD_W'(sync_w);
  assign dec      = decode_addr(addr_i, NB);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int unsigned PB = (b == NB - 1) ? NUM_PINS - BANK_W * b : BANK_W;
    logic wr_b;
    assign wr_b = req_i && we_i && dec.hit && (dec.bank == 3'(b));

    gpio_bank #(.PINS(PB)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pins_all[BANK_W*b +: PB]),
      .wr_i    (wr_b),
      .grp_i   (dec.grp),
      .wdata_i (wdata_i[PB-1:0]),
      .rdata_o (bank_rd[b]),
      .dir_o   (pad_oe_o[BANK_W*b +: PB]),
      .out_o   (pad_out_o[BANK_W*b +: PB]),
      .irq_o   (bank_irq[b])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int b = 0; b < NB; b++) begin
      if (dec.bank == 3'(b)) rd_sel = bank_rd[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rdata_q <= '0;
    else if (req_i && !we_i && dec.hit) rdata_q <= rd_sel;
    else if (req_i && !we_i)           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |bank_irq;

  a_r3_set_clr_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && dec.hit && (dec.grp == G_SET || dec.grp == G_CLR)) |=> (rdata_o == '0));

  a_r10_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !dec.hit) |=> (rdata_o == '0));

  a_r8_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$stable(bank_irq));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int NP = 120;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad = '0;
  logic [NP-1:0] pout, poe;
  logic          irq;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend = 1'b0;

  always #4 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad), .pad_out_o(pout),
    .pad_oe_o(poe), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 map: group base plus bank placement
  function automatic logic [8:0] a_of(input int base, input int b);
    return 9'(base + ((b < 3) ? 4 * b : 'h100 + 4 * (b - 3)));
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); req = 1'b0;
  endtask

  // monitor: compare read data one edge after the request
  always @(posedge clk) rd_pend <= req && !we;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", 32'(irq), 0);
    check("R1 oe", 32'(|poe), 0);
    check("R1 out", 32'(|pout), 0);
    rd(a_of('h0C, 0), 0, "R1 dir b0");
    rd(a_of('h9C, 0), 32'hFFFF_FFFF, "R1 mask b0");
    rd(a_of('h9C, 3), 32'h00FF_FFFF, "R9 mask b3 upper bits zero");

    // R4 direction and set/clear on bank 1
    wr(a_of('h0C, 1), 32'h0000_00F0);
    @(negedge clk);
    check("R4 oe b1", poe[63:32], 32'h0000_00F0);
    rd(a_of('h0C, 1), 32'h0000_00F0, "R2 dir b1");
    wr(a_of('h18, 1), 32'h0000_0030);
    check("R4 set b1", pout[63:32], 32'h0000_0030);
    wr(a_of('h24, 1), 32'h0000_0010);
    check("R4 clr b1", pout[63:32], 32'h0000_0020);
    rd(a_of('h18, 1), 0, "R3 set reads zero");
    rd(a_of('h24, 1), 0, "R3 clr reads zero");

    // R3 level follows pads on input and output pins
    @(negedge clk); pad[36] = 1'b1; pad[40] = 1'b1;
    settle();
    rd(a_of('h00, 1), 32'h0000_0110, "R3 level b1");

    // R5 edge capture on bank 0: pin3 rise, pin5 fall, pin7 both
    wr(a_of('h30, 0), 32'h0000_0088);
    wr(a_of('h3C, 0), 32'h0000_00A0);
    pad[3] = 1'b1; pad[5] = 1'b1; pad[7] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 irq not yet after two edges", 32'(irq), 0);
    @(negedge clk);
    check("R8 irq after three edges", 32'(irq), 1);
    rd(a_of('h48, 0), 32'h0000_0088, "R5 rising capture");
    @(negedge clk); pad[3] = 1'b0; pad[5] = 1'b0; pad[7] = 1'b0;
    settle();
    rd(a_of('h48, 0), 32'h0000_00A8, "R5 falling capture sticky");

    // R6 write-one-to-clear
    wr(a_of('h48, 0), 32'h0000_0008);
    rd(a_of('h48, 0), 32'h0000_00A0, "R6 clear one bit");
    wr(a_of('h48, 0), 32'h0000_0000);
    rd(a_of('h48, 0), 32'h0000_00A0, "R6 zero write no effect");

    // R8 mask
    wr(a_of('h9C, 0), 32'h0000_0000);
    check("R8 masked irq", 32'(irq), 0);
    rd(a_of('h48, 0), 32'h0000_00A0, "R8 status kept while masked");
    wr(a_of('h9C, 0), 32'hFFFF_FFFF);
    check("R8 unmasked irq", 32'(irq), 1);

    // R7 edge on pin7 collides with a clear of bit 7
    @(negedge clk); pad[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a_of('h48, 0); wdata = 32'h0000_0080;
    @(negedge clk); req = 1'b0; we = 1'b0;
    rd(a_of('h48, 0), 32'h0000_00A0, "R7 edge wins over clear");
    wr(a_of('h48, 0), 32'hFFFF_FFFF);
    rd(a_of('h48, 0), 0, "R6 clear all");
    check("R8 irq low after clear all", 32'(irq), 0);

    // R2 upper block: bank 3 at 0x100
    wr(a_of('h30, 3), 32'h0000_0010);
    @(negedge clk); pad[100] = 1'b1;
    settle();
    rd(a_of('h48, 3), 32'h0000_0010, "R2 bank3 status");
    rd(a_of('h48, 2), 0, "R2 bank2 untouched");
    check("R8 irq from bank3", 32'(irq), 1);
    wr(a_of('h48, 3), 32'hFFFF_FFFF);

    // R9 partial bank
    wr(a_of('h0C, 3), 32'hFFFF_FFFF);
    rd(a_of('h0C, 3), 32'h00FF_FFFF, "R9 dir b3 width");
    check("R9 oe b3", {8'h0, poe[119:96]}, 32'h00FF_FFFF);

    // R10 unmapped offsets
    wr(9'h054, 32'hFFFF_FFFF);
    rd(9'h054, 0, "R10 unmapped reads zero");
    rd(a_of('h0C, 0), 0, "R10 unmapped write ignored");
    rd(a_of('h0C, 4), 0, "R10 absent bank reads zero");
    check("R10 irq unchanged", 32'(irq), 0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule